// File: doc/BRIEF.md
# PCI Configuration Access Bridge

This block lets a processor reach the configuration space of devices on the local PCI bus through two windows of a simple register bus. A write to the low window loads a 32-bit configuration address register, and a read of that window returns it. The register is kept in the processor's byte order, so once it is viewed as a PCI configuration address its fields sit at swapped positions. Accesses to the high window are turned into Type 0 configuration reads or writes of one dword on the target that the address register selects. This happens only while the register's enable bit is set.

Three external target slots, at device numbers 13, 14 and 15 with function 0, are reached through a simple register-file port. Each slot has a one-hot select strobe, a write flag, a dword index, write data and a read-data lane per slot. The bridge answers for device 0, function 0 itself from a small internal header. Any cycle aimed at another bus, or at a device that is absent, reads as all ones and writes nothing. Reads of a byte or halfword come back in processor byte order, right-justified. A write of less than a whole aligned dword is carried out as a read of the target dword, a merge of the new bytes, and a write-back.

Top module: `cfg_access_bridge`

## Requirements
- R1: After reset the address register is zero, `rsp_ready` is low and no `tgt_sel` bit is set.
- R2: An access with `req_offset` below 0x200000 is an address-window access. A write loads `req_wdata` into the address register whatever `req_size` is. A read returns the register. Neither raises any strobe.
- R3: A data-window access (`req_offset` at or above 0x200000) made while address-register bit 7 is 0 reads as 0, writes nothing and raises no strobe.
- R4: The address register fields are bus = bits [15:8], function = bits [18:16], device = bits [23:19] and dword index = bits [31:26] (bits [25:24] are ignored). The dword index appears on `tgt_reg`. Device 13+s with function 0 selects `tgt_sel[s]`.
- R5: A data-window access with a non-zero bus field reads as 0xFFFFFFFF, writes nothing and raises no strobe.
- R6: A data-window access to a device/function pair with no target reads as 0xFFFFFFFF, writes nothing and raises no strobe. This covers any function other than 0, a device other than 0, 13, 14 or 15, and a slot whose `slot_present` bit is low.
- R7: Device 0, function 0 is the bridge itself. Dword 0 reads as `SELF_ID` and ignores writes. Dwords 1 to `SELF_WORDS`-1 are writable and reset to zero. All higher dwords read as zero. No strobe is raised.
- R8: `req_size` 0, 1 and 2 (or 3) mean 1, 2 and 4 bytes, and the lane is `req_offset[1:0]`. A read returns bytes lane..lane+n-1 of the target dword with the lowest lane most significant, right-justified and zero-extended. Bytes past lane 3 read as zero. A 4-byte read at lane 0 is therefore the target dword byte-reversed.
- R9: A 4-byte write at lane 0 to an external slot raises a single write strobe. Its `tgt_wdata` is `req_wdata` byte-reversed.
- R10: Any other write to an external slot raises a read strobe and then, in the next cycle, a write strobe to the same slot and dword. The written dword is the old dword with the new bytes placed in the selected lanes, the lowest lane taking the most significant byte. Bytes that would fall past lane 3 are dropped.
- R11: Each accepted request gets exactly one single-cycle `rsp_ready` pulse. Before that pulse the access raises 0, 1 or 2 strobes with at most one `tgt_sel` bit set at a time. `rsp_rdata` is zero for writes.
- R12: `req_valid` is taken only when the bridge is idle. A request presented while an access is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | OFS_W | Offset within the bridge window |
| req_size | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ready` |
| tgt_sel | output | NUM_SLOTS | One-hot target slot strobe |
| tgt_we | output | 1 | Strobe is a write |
| tgt_reg | output | 6 | Target dword index |
| tgt_wdata | output | 32 | Target write dword |
| tgt_rdata | input | 32*NUM_SLOTS | Read dword from each slot, slot s at bits [32s+31:32s] |
| slot_present | input | NUM_SLOTS | A target is attached at slot s |

## Verification
The bench goes after the byte lanes. It uses halfword and dword accesses that cross past lane 3, where a design that wrapped lanes would corrupt byte 0. It also checks that every partial write keeps the bytes it did not select, which a design that wrote without reading first would clear. It places random values in the ignored low bits of the register byte and in the function field, so a design that decoded the fields at unswapped positions would strobe the wrong slot or register. It also covers disabled, off-bus and absent targets, including a slot whose present bit is low, where a wrong design would strobe or return stale data. Finally it presents a second request while an access is in progress, which a design that restarted on it would apply to the address register.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_RD,
    ST_WR,
    ST_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    RT_ADDR,
    RT_OFF,
    RT_NONE,
    RT_SELF,
    RT_SLOT
  } route_e;

  function automatic int size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // Pull bytes lane..lane+n-1 of a target dword into processor order.
  function automatic logic [31:0] lane_extract(input logic [31:0] dw,
                                               input logic [1:0] lane,
                                               input logic [1:0] sz);
    logic [31:0] r;
    int n;
    n = size_bytes(sz);
    r = '0;
    for (int k = 0; k < 4; k++) begin
      if (k < n && int'(lane) + k < 4)
        r[8*(n-1-k) +: 8] = dw[8*(int'(lane)+k) +: 8];
    end
    return r;
  endfunction

  // Place processor-order bytes into the selected lanes of a dword.
  function automatic logic [31:0] lane_merge(input logic [31:0] old,
                                             input logic [31:0] val,
                                             input logic [1:0] lane,
                                             input logic [1:0] sz);
    logic [31:0] r;
    int n;
    n = size_bytes(sz);
    r = old;
    for (int k = 0; k < 4; k++) begin
      if (k < n && int'(lane) + k < 4)
        r[8*(int'(lane)+k) +: 8] = val[8*(n-1-k) +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/cfgb_rst_sync.sv
module cfgb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/cfgb_addr_decode.sv
module cfgb_addr_decode
  import cfgb_pkg::*;
#(
  parameter int NUM_SLOTS  = 3,
  parameter int SLOT_BASE  = 13,
  parameter int SLOT_IDX_W = 2
) (
  input  logic [31:0]           cfg_addr,
  input  logic                  is_data,
  input  logic [NUM_SLOTS-1:0]  slot_present,
  output route_e                route,
  output logic [SLOT_IDX_W-1:0] slot_idx,
  output logic [5:0]            reg_idx
);
  logic [7:0] bus_f;
  logic [4:0] dev_f;
  logic [2:0] fun_f;
  logic [NUM_SLOTS-1:0] hit;
  logic unused_bits;

  // byte-swapped layout: register byte on top, bus in the second byte
  assign bus_f   = cfg_addr[15:8];
  assign fun_f   = cfg_addr[18:16];
  assign dev_f   = cfg_addr[23:19];
  assign reg_idx = cfg_addr[31:26];
  assign unused_bits = ^{cfg_addr[25:24], cfg_addr[6:0]};

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hit
    assign hit[s] = slot_present[s] && (fun_f == 3'd0) &&
                    (dev_f == 5'(SLOT_BASE + s));
  end

  always_comb begin
    slot_idx = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (hit[s]) slot_idx = SLOT_IDX_W'(s);
    end
  end

  always_comb begin
    if (!is_data)                               route = RT_ADDR;
    else if (!cfg_addr[7])                      route = RT_OFF;
    else if (bus_f != 8'd0)                     route = RT_NONE;
    else if (dev_f == 5'd0 && fun_f == 3'd0)    route = RT_SELF;
    else if (|hit)                              route = RT_SLOT;
    else                                        route = RT_NONE;
  end
endmodule

// File: rtl/cfgb_self_regs.sv
module cfgb_self_regs #(
  parameter int          SELF_WORDS = 4,
  parameter logic [31:0] SELF_ID    = 32'h4C1E_0B57
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  idx,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data
);
  logic [31:0] word_q [SELF_WORDS];

  assign word_q[0] = SELF_ID;

  for (genvar w = 1; w < SELF_WORDS; w++) begin : g_word
    logic wen;
    assign wen = wr_en && (int'(idx) == w);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[w] <= '0;
      else if (wen) word_q[w] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < SELF_WORDS; w++) begin
      if (int'(idx) == w) rd_data = word_q[w];
    end
  end
endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge
  import cfgb_pkg::*;
#(
  parameter int          NUM_SLOTS  = 3,
  parameter int          SLOT_BASE  = 13,
  parameter int          SELF_WORDS = 4,
  parameter logic [31:0] SELF_ID    = 32'h4C1E_0B57,
  parameter int          OFS_W      = 22,
  parameter logic [31:0] DATA_BASE  = 32'h0020_0000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [OFS_W-1:0]       req_offset,
  input  logic [1:0]             req_size,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_ready,
  output logic [31:0]            rsp_rdata,
  output logic [NUM_SLOTS-1:0]   tgt_sel,
  output logic                   tgt_we,
  output logic [5:0]             tgt_reg,
  output logic [31:0]            tgt_wdata,
  input  logic [32*NUM_SLOTS-1:0] tgt_rdata,
  input  logic [NUM_SLOTS-1:0]   slot_present
);
  localparam int SLOT_IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic srst_n;
  cfgb_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  seq_state_e state_q, state_d;
  logic [31:0] addr_q, addr_d;
  logic        addr_en;
  logic        cap_en;
  logic        wr_q, data_q;
  logic [1:0]  lane_q, size_q;
  logic [31:0] wdata_q;
  logic [SLOT_IDX_W-1:0] slot_q;
  logic [5:0]  reg_q;
  logic        tsel_en;
  logic [31:0] wword_q, wword_d;
  logic        wword_en;
  logic [31:0] rdata_q, rdata_d;
  logic        rdata_en;

  route_e                dec_route;
  logic [SLOT_IDX_W-1:0] dec_slot;
  logic [5:0]            dec_reg;

  logic [31:0] self_rd, self_wdata;
  logic        self_we;
  logic [31:0] slot_rd;
  logic        full_wr;

  cfgb_addr_decode #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_BASE(SLOT_BASE), .SLOT_IDX_W(SLOT_IDX_W)
  ) u_dec (
    .cfg_addr(addr_q), .is_data(data_q), .slot_present(slot_present),
    .route(dec_route), .slot_idx(dec_slot), .reg_idx(dec_reg)
  );

  cfgb_self_regs #(.SELF_WORDS(SELF_WORDS), .SELF_ID(SELF_ID)) u_self (
    .clk(clk), .rst_n(srst_n), .idx(dec_reg), .wr_en(self_we),
    .wr_data(self_wdata), .rd_data(self_rd)
  );

  assign slot_rd = tgt_rdata[32*int'(slot_q) +: 32];
  assign full_wr = (size_bytes(size_q) == 4) && (lane_q == 2'd0);

  // next-state and datapath selection
  always_comb begin
    state_d    = state_q;
    addr_d     = wdata_q;
    addr_en    = 1'b0;
    cap_en     = 1'b0;
    tsel_en    = 1'b0;
    wword_d    = '0;
    wword_en   = 1'b0;
    rdata_d    = '0;
    rdata_en   = 1'b0;
    self_we    = 1'b0;
    self_wdata = lane_merge(self_rd, wdata_q, lane_q, size_q);
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_en  = 1'b1;
          state_d = ST_DECODE;
        end
      end
      ST_DECODE: begin
        rdata_en = 1'b1;
        state_d  = ST_DONE;
        unique case (dec_route)
          RT_ADDR: begin
            addr_en = wr_q;
            rdata_d = wr_q ? 32'h0 : addr_q;
          end
          RT_OFF:  rdata_d = 32'h0;
          RT_NONE: rdata_d = wr_q ? 32'h0 : 32'hFFFF_FFFF;
          RT_SELF: begin
            self_we = wr_q;
            rdata_d = wr_q ? 32'h0 : lane_extract(self_rd, lane_q, size_q);
          end
          RT_SLOT: begin
            rdata_en = 1'b0;
            tsel_en  = 1'b1;
            if (wr_q && full_wr) begin
              wword_en = 1'b1;
              wword_d  = lane_merge(32'h0, wdata_q, lane_q, size_q);
              state_d  = ST_WR;
            end else begin
              state_d  = ST_RD;
            end
          end
          default: ;
        endcase
      end
      ST_RD: begin
        if (wr_q) begin
          wword_en = 1'b1;
          wword_d  = lane_merge(slot_rd, wdata_q, lane_q, size_q);
          state_d  = ST_WR;
        end else begin
          rdata_en = 1'b1;
          rdata_d  = lane_extract(slot_rd, lane_q, size_q);
          state_d  = ST_DONE;
        end
      end
      ST_WR: begin
        rdata_en = 1'b1;
        rdata_d  = 32'h0;
        state_d  = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      data_q  <= 1'b0;
      lane_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
      slot_q  <= '0;
      reg_q   <= '0;
      wword_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (addr_en) addr_q <= addr_d;
      if (cap_en) begin
        wr_q    <= req_write;
        data_q  <= (32'(req_offset) >= DATA_BASE);
        lane_q  <= req_offset[1:0];
        size_q  <= req_size;
        wdata_q <= req_wdata;
      end
      if (tsel_en) begin
        slot_q <= dec_slot;
        reg_q  <= dec_reg;
      end
      if (wword_en) wword_q <= wword_d;
      if (rdata_en) rdata_q <= rdata_d;
    end
  end

  always_comb begin
    tgt_sel = '0;
    if (state_q == ST_RD || state_q == ST_WR) tgt_sel[slot_q] = 1'b1;
  end

  assign tgt_we    = (state_q == ST_WR);
  assign tgt_reg   = reg_q;
  assign tgt_wdata = wword_q;
  assign rsp_ready = (state_q == ST_DONE);
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/cfg_access_bridge_chk.sv
module cfg_access_bridge_chk #(
  parameter int NUM_SLOTS = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rsp_ready,
  input logic [NUM_SLOTS-1:0] tgt_sel,
  input logic                 tgt_we,
  input logic [NUM_SLOTS-1:0] slot_present
);
  // R11: completion is a single-cycle pulse
  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready);

  // R11: never more than one slot strobed
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel));

  // R11: no strobe in the completion cycle
  a_r11_quiet_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> (tgt_sel == '0));

  // R10: a read strobe is followed by completion or a write to the same slot
  a_r10_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((|tgt_sel) && !tgt_we) |=>
      (rsp_ready || (tgt_we && tgt_sel == $past(tgt_sel))));

  // R9: a write strobe ends the access
  a_r9_write_ends: assert property (@(posedge clk) disable iff (!rst_n)
    ((|tgt_sel) && tgt_we) |=> (rsp_ready && (tgt_sel == '0)));

  // R6: absent slots are never strobed
  a_r6_present_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((tgt_sel & ~slot_present) == '0));
endmodule

bind cfg_access_bridge cfg_access_bridge_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_ready(rsp_ready), .tgt_sel(tgt_sel),
  .tgt_we(tgt_we), .slot_present(slot_present)
);

// File: tb/sim_cfg_access_bridge.sv
module sim_cfg_access_bridge;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] ID_WORD    = 32'h4C1E_0B57;
  localparam int          SELF_N     = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [21:0] req_offset = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready;
  logic [31:0] rsp_rdata;
  logic [2:0]  tgt_sel;
  logic        tgt_we;
  logic [5:0]  tgt_reg;
  logic [31:0] tgt_wdata;
  logic [95:0] tgt_rdata;
  logic [2:0]  present = 3'b111;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_access_bridge u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .tgt_sel(tgt_sel),
    .tgt_we(tgt_we), .tgt_reg(tgt_reg), .tgt_wdata(tgt_wdata),
    .tgt_rdata(tgt_rdata), .slot_present(present)
  );

  function automatic logic [31:0] pat(input int s, input int r);
    return 32'hA500_0000 ^ (32'(s) << 16) ^ (32'(r) * 32'h0000_0101) ^ 32'h0030_0C00;
  endfunction

  // target register files
  logic [31:0] tmem [3][64];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 3; s++)
        for (int r = 0; r < 64; r++) tmem[s][r] <= pat(s, r);
    end else begin
      for (int s = 0; s < 3; s++)
        if (tgt_sel[s] && tgt_we) tmem[s][tgt_reg] <= tgt_wdata;
    end
  end
  always_comb begin
    for (int s = 0; s < 3; s++) tgt_rdata[32*s +: 32] = tmem[s][tgt_reg];
  end

  // strobe monitor
  int         stb_total = 0;
  logic [1:0] stb_hist = '0;
  logic [5:0] stb_reg = '0;
  logic [2:0] stb_sel = '0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (|tgt_sel) begin
      stb_total <= stb_total + 1;
      stb_hist  <= {stb_hist[0], tgt_we};
      stb_reg   <= tgt_reg;
      stb_sel   <= tgt_sel;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model state
  logic [31:0] exp_addr = '0;
  logic [31:0] exp_self [SELF_N];
  logic [31:0] exp_mem [3][64];

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] fmt_read(input logic [31:0] t, input int lane, input int n);
    logic [31:0] r = '0;
    for (int k = 0; k < n; k++)
      r = {r[23:0], (lane + k < 4) ? t[8*(lane+k) +: 8] : 8'h00};
    return r;
  endfunction

  function automatic logic [31:0] fmt_write(input logic [31:0] t, input logic [31:0] w,
                                            input int lane, input int n);
    logic [31:0] r = t;
    for (int k = 0; k < n; k++)
      if (lane + k < 4) r[8*(lane+k) +: 8] = w[8*(n-1-k) +: 8];
    return r;
  endfunction

  // -3 disabled, -4 other bus, -2 absent, -1 self, 0..2 slot
  function automatic int route_of(input logic [31:0] a, input logic [2:0] pres);
    int bus = int'((a >> 8) & 32'hFF);
    int dev = int'((a >> 19) & 32'h1F);
    int fun = int'((a >> 16) & 32'h7);
    if (!a[7]) return -3;
    if (bus != 0) return -4;
    if (fun != 0) return -2;
    if (dev == 0) return -1;
    if (dev >= 13 && dev <= 15 && pres[dev-13]) return dev - 13;
    return -2;
  endfunction

  task automatic ref_access(input logic wr, input logic [21:0] ofs, input logic [1:0] sz,
                            input logic [31:0] wd, output logic [31:0] er, output int ens,
                            output int eslot, output int ereg, output string tag);
    int n = nbytes(sz);
    int lane = int'(ofs[1:0]);
    int rt;
    logic [31:0] old;
    er = 32'h0; ens = 0; eslot = -1; ereg = int'(exp_addr[31:26]);
    if (ofs < 22'h200000) begin
      tag = "R2 address window";
      if (wr) exp_addr = wd; else er = exp_addr;
      return;
    end
    rt = route_of(exp_addr, present);
    case (rt)
      -3: tag = "R3 disabled";
      -4: begin tag = "R5 other bus"; if (!wr) er = 32'hFFFF_FFFF; end
      -2: begin tag = "R6 absent"; if (!wr) er = 32'hFFFF_FFFF; end
      -1: begin
        tag = "R7 self header";
        old = (ereg == 0) ? ID_WORD : (ereg < SELF_N) ? exp_self[ereg] : 32'h0;
        if (wr) begin
          if (ereg >= 1 && ereg < SELF_N) exp_self[ereg] = fmt_write(old, wd, lane, n);
        end else er = fmt_read(old, lane, n);
      end
      default: begin
        eslot = rt;
        old = exp_mem[rt][ereg];
        if (wr) begin
          exp_mem[rt][ereg] = fmt_write(old, wd, lane, n);
          if (n == 4 && lane == 0) begin ens = 1; tag = "R9 full write"; end
          else begin ens = 2; tag = "R10 partial write"; end
        end else begin
          er = fmt_read(old, lane, n); ens = 1; tag = "R8 slot read";
        end
      end
    endcase
  endtask

  task automatic access(input logic wr, input logic [21:0] ofs, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output int nstb);
    int base = stb_total;
    int waited = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_offset = ofs; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_ready && waited < 20) begin @(negedge clk); waited++; end
    check(rsp_ready, "R11 completion", 32'(rsp_ready), 32'h1);
    rd = rsp_rdata;
    nstb = stb_total - base;
    @(negedge clk);
    check(!rsp_ready, "R11 single pulse", 32'(rsp_ready), 32'h0);
  endtask

  task automatic run(input logic wr, input logic [21:0] ofs, input logic [1:0] sz,
                     input logic [31:0] wd);
    logic [31:0] er, rd;
    int ens, eslot, ereg, nstb;
    string tag;
    ref_access(wr, ofs, sz, wd, er, ens, eslot, ereg, tag);
    access(wr, ofs, sz, wd, rd, nstb);
    check(rd == er, tag, rd, er);
    check(nstb == ens, "R11 strobe count", 32'(nstb), 32'(ens));
    if (ens > 0 && nstb == ens) begin
      check(stb_reg == 6'(ereg), "R4 register index", 32'(stb_reg), 32'(ereg));
      check(stb_sel == 3'(1 << eslot), "R4 slot select", 32'(stb_sel), 32'(1 << eslot));
    end
    if (ens == 2 && nstb == 2)
      check(stb_hist == 2'b01, "R10 read then write", 32'(stb_hist), 32'h1);
    if (wr && ens > 0)
      check(tmem[eslot][ereg] == exp_mem[eslot][ereg], tag,
            tmem[eslot][ereg], exp_mem[eslot][ereg]);
  endtask

  function automatic logic [31:0] mk_addr(input logic en, input logic [7:0] bus,
                                          input logic [4:0] dev, input logic [2:0] fun,
                                          input logic [5:0] rg);
    return {rg, 2'($urandom_range(0, 3)), dev, fun, bus, en, 7'($urandom_range(0, 127))};
  endfunction

  function automatic logic [21:0] dofs(input logic [1:0] lane);
    return {1'b1, 19'($urandom), lane};
  endfunction

  initial begin
    logic [31:0] rd;
    int nstb;
    void'($urandom(32'd715));
    for (int w = 0; w < SELF_N; w++) exp_self[w] = 32'h0;
    for (int s = 0; s < 3; s++)
      for (int r = 0; r < 64; r++) exp_mem[s][r] = pat(s, r);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(!rsp_ready, "R1 ready after reset", 32'(rsp_ready), 32'h0);
    check(tgt_sel == 3'b000, "R1 no strobe after reset", 32'(tgt_sel), 32'h0);
    run(1'b0, 22'h000004, 2'd2, 32'h0);

    // R2 address window, odd size on the write
    run(1'b1, 22'h0ABCDE, 2'd0, 32'h1234_5678);
    run(1'b0, 22'h1FFFFF, 2'd1, 32'h0);

    // R3 disabled: read 0, write dropped, then enable and confirm untouched
    run(1'b1, 22'h0, 2'd2, mk_addr(1'b0, 8'h00, 5'd13, 3'd0, 6'd5));
    run(1'b0, dofs(2'd0), 2'd2, 32'h0);
    run(1'b1, dofs(2'd0), 2'd2, 32'hCAFE_F00D);
    run(1'b1, 22'h0, 2'd2, mk_addr(1'b1, 8'h00, 5'd13, 3'd0, 6'd5));
    run(1'b0, dofs(2'd0), 2'd2, 32'h0);

    // R5 other bus
    run(1'b1, 22'h0, 2'd2, mk_addr(1'b1, 8'h01, 5'd13, 3'd0, 6'd2));
    run(1'b0, dofs(2'd0), 2'd2, 32'h0);
    run(1'b1, dofs(2'd0), 2'd2, 32'h1111_2222);

    // R6 absent: function 1, then slot 1 not present
    run(1'b1, 22'h0, 2'd2, mk_addr(1'b1, 8'h00, 5'd14, 3'd1, 6'd2));
    run(1'b0, dofs(2'd0), 2'd2, 32'h0);
    present = 3'b101;
    run(1'b1, 22'h0, 2'd2, mk_addr(1'b1, 8'h00, 5'd14, 3'd0, 6'd3));
    run(1'b0, dofs(2'd1), 2'd0, 32'h0);
    run(1'b1, dofs(2'd0), 2'd2, 32'h3333_4444);
    present = 3'b111;
    run(1'b0, dofs(2'd0), 2'd2, 32'h0);

    // R7 self header
    run(1'b1, 22'h0, 2'd2, mk_addr(1'b1, 8'h00, 5'd0, 3'd0, 6'd0));
    run(1'b0, dofs(2'd0), 2'd2, 32'h0);
    run(1'b1, dofs(2'd0), 2'd2, 32'hFFFF_FFFF);
    run(1'b0, dofs(2'd2), 2'd1, 32'h0);
    run(1'b1, 22'h0, 2'd2, mk_addr(1'b1, 8'h00, 5'd0, 3'd0, 6'd2));
    run(1'b1, dofs(2'd1), 2'd0, 32'h0000_00AB);
    run(1'b0, dofs(2'd0), 2'd2, 32'h0);

    // R9 full write, R10 partial writes including lane overrun, R8 reads
    run(1'b1, 22'h0, 2'd2, mk_addr(1'b1, 8'h00, 5'd15, 3'd0, 6'd63));
    run(1'b1, dofs(2'd0), 2'd2, 32'h0102_0304);
    run(1'b0, dofs(2'd0), 2'd2, 32'h0);
    run(1'b1, dofs(2'd3), 2'd0, 32'h0000_00EE);
    run(1'b1, dofs(2'd3), 2'd1, 32'h0000_5A6B);
    run(1'b1, dofs(2'd1), 2'd2, 32'h9988_7766);
    run(1'b0, dofs(2'd3), 2'd1, 32'h0);
    run(1'b0, dofs(2'd2), 2'd1, 32'h0);
    run(1'b0, dofs(2'd1), 2'd0, 32'h0);

    // R12 a request while busy is ignored
    run(1'b1, 22'h0, 2'd2, mk_addr(1'b1, 8'h00, 5'd13, 3'd0, 6'd7));
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_offset = dofs(2'd0); req_size = 2'd2;
    @(negedge clk);
    req_write = 1'b1; req_offset = 22'h000010; req_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 20 && !rsp_ready; i++) @(negedge clk);
    @(negedge clk);
    access(1'b0, 22'h000020, 2'd2, 32'h0, rd, nstb);
    check(rd == exp_addr, "R12 busy request ignored", rd, exp_addr);

    // constrained random mix
    for (int i = 0; i < 800; i++) begin
      int c = $urandom_range(0, 9);
      if (i % 64 == 0) present = 3'($urandom_range(0, 7));
      if (c < 3) begin
        int pick = $urandom_range(0, 5);
        logic [4:0] dv;
        logic [7:0] bs;
        logic [2:0] fn;
        dv = (pick == 0) ? 5'd0 : (pick <= 3) ? 5'(12 + pick) :
             (pick == 4) ? 5'($urandom_range(0, 31)) : 5'd12;
        bs = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(1, 255)) : 8'h00;
        fn = ($urandom_range(0, 5) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
        run(1'b1, 22'($urandom_range(0, 32'h1F_FFFF)), 2'($urandom_range(0, 3)),
            mk_addr($urandom_range(0, 7) != 0, bs, dv, fn,
                    (dv == 5'd0) ? 6'($urandom_range(0, 5)) : 6'($urandom_range(0, 63))));
      end else if (c == 3) begin
        run(1'b0, 22'($urandom_range(0, 32'h1F_FFFF)), 2'($urandom_range(0, 3)), 32'h0);
      end else begin
        run(1'($urandom_range(0, 1)), dofs(2'($urandom_range(0, 3))),
            2'($urandom_range(0, 3)), $urandom);
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule